// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status Unit

This unit turns the synchronized levels of a 32-pin port into interrupt requests. Each pin has its own 4-bit sense code. The code selects rising edge, falling edge, high level, low level or both edges. When a pin's condition is met and detection is enabled for that pin, the unit sets a per-pin pending bit. The pending bit stays set until software acknowledges it.

Software controls the unit through a simple write-strobe register bus with a combinational read port. A detection-enable word gates whether new events are recorded. Separate set and clear addresses unmask or mask each pin's contribution to the interrupt lines. The raw pending bits and the masked view can each be read back. Two request lines come out of the unit: one for pins 15..0 and one for pins 31..16.

To change a pin's mode safely, software first disables detection for that pin. It then rewrites the sense field, acknowledges the pin, and re-enables detection.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, the detection-enable, unmask, raw pending, masked status and all sense fields read 0, and both request lines are low.
- R2: With sense code 0, a pending bit is set only on a 0-to-1 change of the pin, seen one clock after the new level is presented. A 1-to-0 change sets nothing.
- R3: With sense code 1, a pending bit is set only on a 1-to-0 change of the pin.
- R4: With sense code 2 (high) or 3 (low), the pending bit is set while the level is present. An acknowledge while the level persists leaves it set. An acknowledge after the level is gone clears it.
- R5: With sense code 4, both a rising and a falling change set the pending bit.
- R6: Offset 0x14 is a read/write detection-enable word. A pin whose bit is 0 records no new pending event.
- R7: Writing 1s at offset 0x18 unmasks those pins, and writing 1s at offset 0x1C masks them. Zero bits have no effect. Reading 0x18 or 0x1C returns the unmask word, where 1 means unmasked.
- R8: Offset 0x20 reads the raw pending bits. Offset 0x24 reads the raw pending bits ANDed with the unmask word.
- R9: Writing 1s at offset 0x28 clears those pending bits, and 0 bits leave their pins untouched. If a new event for a pin arrives in the same cycle as its clear, the event wins and the bit stays set.
- R10: The low request line is the OR of masked status bits 15..0, and the high request line is the OR of bits 31..16.
- R11: Pin p's sense field sits at bits 4*(p%8)+3..4*(p%8) of the register at offset 0x40+4*(p/8), and reads back as written. Bit 3 of a field (the asynchronous flag) does not change detection. Codes 5 to 7 detect nothing.
- R12: The change sequence leaves no pending bit on a pin whose level does not meet the new mode. The sequence is: detection off, sense rewrite, acknowledge, detection on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 32 | Synchronized pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |
| irq_lo | output | 1 | Request line for pins 15..0 |
| irq_hi | output | 1 | Request line for pins 31..16 |

## Verification
Each sense code is driven with both a rising and a falling pin transition, so that the edge modes can be told apart from each other and from the level modes. The level modes are also acknowledged with the level still present and then again with it removed; this separates persistent level detection from one-shot edge capture. A pin is toggled in the same cycle as its acknowledge, which shows whether the event or the clear has priority. Finally, mode changes on a pin held high show whether the change sequence can create a spurious pending bit.

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int NPINS = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] pin_in,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_lo,
  output logic        irq_hi
);
  localparam int HALF = NPINS / 2;
  localparam int NGRP = NPINS / 8;

  logic [NPINS-1:0] pin_q, det_en, unmask, pend, ev, ack, masked;
  logic [3:0]       sense [NPINS];
  logic [31:0]      sense_rd [NGRP];

  wire wr_en  = bus_wr && (bus_addr == 8'h14);
  wire wr_set = bus_wr && (bus_addr == 8'h18);
  wire wr_clr = bus_wr && (bus_addr == 8'h1C);
  wire wr_ack = bus_wr && (bus_addr == 8'h28);

  assign ack    = wr_ack ? bus_wdata : '0;
  assign masked = pend & unmask;
  assign irq_lo = |masked[HALF-1:0];
  assign irq_hi = |masked[NPINS-1:HALF];

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      case (sense[i][2:0])
        3'd0:    ev[i] =  pin_in[i] & ~pin_q[i];
        3'd1:    ev[i] = ~pin_in[i] &  pin_q[i];
        3'd2:    ev[i] =  pin_in[i];
        3'd3:    ev[i] = ~pin_in[i];
        3'd4:    ev[i] =  pin_in[i] ^  pin_q[i];
        default: ev[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= '0;
      det_en <= '0;
      unmask <= '0;
      pend   <= '0;
      for (int i = 0; i < NPINS; i++) sense[i] <= '0;
    end else begin
      pin_q <= pin_in;
      pend  <= (pend & ~ack) | (ev & det_en);
      if (wr_en)  det_en <= bus_wdata;
      if (wr_set) unmask <= unmask | bus_wdata;
      if (wr_clr) unmask <= unmask & ~bus_wdata;
      for (int g = 0; g < NGRP; g++)
        if (bus_wr && bus_addr == 8'(64 + 4 * g))
          for (int j = 0; j < 8; j++) sense[8*g+j] <= bus_wdata[4*j +: 4];
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_rd
    for (genvar j = 0; j < 8; j++) begin : g_fld
      assign sense_rd[g][4*j +: 4] = sense[8*g+j];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      8'h14:          bus_rdata = det_en;
      8'h18, 8'h1C:   bus_rdata = unmask;
      8'h20:          bus_rdata = pend;
      8'h24:          bus_rdata = masked;
      default: begin
        for (int g = 0; g < NGRP; g++)
          if (bus_addr == 8'(64 + 4 * g)) bus_rdata = sense_rd[g];
      end
    endcase
  end
endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] pend,
  input logic [31:0] unmask,
  input logic [31:0] det_en,
  input logic        irq_lo,
  input logic        irq_hi
);
  // R6
  det_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend) & ~$past(det_en)) == 32'h0));

  // R7
  unmask_set_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && bus_addr == 8'h18) |-> ((unmask & $past(bus_wdata)) == $past(bus_wdata)));

  // R7
  unmask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && bus_addr == 8'h1C) |-> ((unmask & $past(bus_wdata)) == 32'h0));

  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (pend == 32'h0) |-> (!irq_lo && !irq_hi));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (unmask == 32'h0) |-> (!irq_lo && !irq_hi));
endmodule

bind gpio_irq_sense gpio_irq_sense_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pend(pend), .unmask(unmask), .det_en(det_en),
  .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/tb_gpio_irq_sense.sv
`timescale 1ns/1ps
module tb_gpio_irq_sense;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_in = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_lo, irq_hi;

  int checks = 0;
  int errors = 0;
  logic [3:0]  shadow [32];
  logic [31:0] det_sh = '0;

  always #2.5 clk = ~clk;

  gpio_irq_sense dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pin(int p, logic v);
    @(negedge clk);
    pin_in[p] = v;
    @(negedge clk);
  endtask

  function automatic logic [31:0] pack(int g);
    logic [31:0] r;
    for (int j = 0; j < 8; j++) r[4*j +: 4] = shadow[8*g+j];
    return r;
  endfunction

  task automatic chg_mode(int p, logic [3:0] code);
    wr(8'h14, det_sh & ~(32'h1 << p));
    shadow[p] = code;
    wr(8'(64 + 4 * (p / 8)), pack(p / 8));
    wr(8'h28, 32'h1 << p);
    wr(8'h14, det_sh);
  endtask

  function automatic logic bitof(logic [31:0] v, int p);
    return v[p];
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h14, d); chk("R1 det_en", d, 0);
    rd(8'h1C, d); chk("R1 unmask", d, 0);
    rd(8'h20, d); chk("R1 raw", d, 0);
    rd(8'h24, d); chk("R1 masked", d, 0);
    rd(8'h44, d); chk("R1 sense", d, 0);
    chk("R1 irqs", {30'h0, irq_hi, irq_lo}, 0);
  endtask

  task automatic t_rising();
    logic [31:0] d;
    set_pin(0, 1'b1);
    rd(8'h20, d); chk("R2 rise sets", 32'(bitof(d, 0)), 1);
    wr(8'h28, 32'h1);
    set_pin(0, 1'b0);
    rd(8'h20, d); chk("R2 fall ignored", 32'(bitof(d, 0)), 0);
  endtask

  task automatic t_falling();
    logic [31:0] d;
    chg_mode(1, 4'd1);
    set_pin(1, 1'b1);
    rd(8'h20, d); chk("R3 rise ignored", 32'(bitof(d, 1)), 0);
    set_pin(1, 1'b0);
    rd(8'h20, d); chk("R3 fall sets", 32'(bitof(d, 1)), 1);
    wr(8'h28, 32'h2);
  endtask

  task automatic t_level();
    logic [31:0] d;
    chg_mode(2, 4'd2);
    rd(8'h20, d); chk("R4 high idle", 32'(bitof(d, 2)), 0);
    set_pin(2, 1'b1);
    rd(8'h20, d); chk("R4 high sets", 32'(bitof(d, 2)), 1);
    wr(8'h28, 32'h4);
    rd(8'h20, d); chk("R4 high persists", 32'(bitof(d, 2)), 1);
    set_pin(2, 1'b0);
    wr(8'h28, 32'h4);
    rd(8'h20, d); chk("R4 high cleared", 32'(bitof(d, 2)), 0);
    chg_mode(3, 4'd3);
    rd(8'h20, d); chk("R4 low sets", 32'(bitof(d, 3)), 1);
    set_pin(3, 1'b1);
    wr(8'h28, 32'h8);
    rd(8'h20, d); chk("R4 low cleared", 32'(bitof(d, 3)), 0);
  endtask

  task automatic t_both();
    logic [31:0] d;
    chg_mode(20, 4'd4);
    rd(8'h48, d); chk("R11 field position", d, 32'h0004_0000);
    set_pin(20, 1'b1);
    rd(8'h20, d); chk("R5 rise sets", 32'(bitof(d, 20)), 1);
    wr(8'h28, 32'h1 << 20);
    rd(8'h20, d); chk("R5 ack clears", 32'(bitof(d, 20)), 0);
    set_pin(20, 1'b0);
    rd(8'h20, d); chk("R5 fall sets", 32'(bitof(d, 20)), 1);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    det_sh = det_sh & ~32'h20;
    wr(8'h14, det_sh);
    rd(8'h14, d); chk("R6 readback", d, det_sh);
    set_pin(5, 1'b1);
    rd(8'h20, d); chk("R6 disabled no pend", 32'(bitof(d, 5)), 0);
    det_sh = 32'hFFFF_FFFF;
    wr(8'h14, det_sh);
    set_pin(5, 1'b0);
  endtask

  task automatic t_mask();
    logic [31:0] d, raw;
    set_pin(0, 1'b1);
    chk("R10 masked lines low", {30'h0, irq_hi, irq_lo}, 0);
    wr(8'h18, 32'h0010_0001);
    rd(8'h1C, d); chk("R7 unmask read", d, 32'h0010_0001);
    rd(8'h18, d); chk("R7 unmask read set addr", d, 32'h0010_0001);
    rd(8'h20, raw);
    rd(8'h24, d); chk("R8 masked view", d, raw & 32'h0010_0001);
    chk("R10 both lines", {30'h0, irq_hi, irq_lo}, 32'h3);
    wr(8'h1C, 32'h0000_0001);
    rd(8'h1C, d); chk("R7 mask clears only ones", d, 32'h0010_0000);
    chk("R10 low masked", {30'h0, irq_hi, irq_lo}, 32'h2);
    wr(8'h28, 32'h0010_0000);
    chk("R10 high cleared", {30'h0, irq_hi, irq_lo}, 32'h0);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h28, 32'h1);
    set_pin(0, 1'b0);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    chg_mode(6, 4'd4);
    set_pin(6, 1'b1);
    rd(8'h20, d); chk("R9 setup", 32'(bitof(d, 6)), 1);
    @(negedge clk);
    pin_in[6] = 1'b0;
    bus_wr = 1'b1; bus_addr = 8'h28; bus_wdata = 32'h40;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(8'h20, d); chk("R9 event wins", 32'(bitof(d, 6)), 1);
    wr(8'h28, 32'h0);
    rd(8'h20, d); chk("R9 zero bits no effect", 32'(bitof(d, 6)), 1);
    wr(8'h28, 32'h40);
    rd(8'h20, d); chk("R9 ack clears", 32'(bitof(d, 6)), 0);
  endtask

  task automatic t_codes();
    logic [31:0] d;
    chg_mode(7, 4'hD);
    set_pin(7, 1'b1);
    set_pin(7, 1'b0);
    rd(8'h20, d); chk("R11 code 5 inert", 32'(bitof(d, 7)), 0);
    chg_mode(7, 4'h8);
    rd(8'h40, d); chk("R11 readback", d[31:28], 32'h8);
    set_pin(7, 1'b1);
    rd(8'h20, d); chk("R11 async flag rising", 32'(bitof(d, 7)), 1);
    wr(8'h28, 32'h80);
  endtask

  task automatic t_modechg();
    logic [31:0] d;
    set_pin(9, 1'b1);
    wr(8'h28, 32'h200);
    chg_mode(9, 4'd1);
    rd(8'h20, d); chk("R12 to falling no spurious", 32'(bitof(d, 9)), 0);
    chg_mode(9, 4'd4);
    rd(8'h20, d); chk("R12 to both no spurious", 32'(bitof(d, 9)), 0);
    chg_mode(9, 4'd3);
    rd(8'h20, d); chk("R12 to low no spurious", 32'(bitof(d, 9)), 0);
    chg_mode(9, 4'd2);
    rd(8'h20, d); chk("R12 to high level seen", 32'(bitof(d, 9)), 1);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) shadow[i] = 4'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    det_sh = 32'hFFFF_FFFF;
    wr(8'h14, det_sh);
    t_rising();
    t_falling();
    t_level();
    t_both();
    t_enable();
    t_mask();
    t_ack();
    t_codes();
    t_modechg();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule